// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block sends a pair of 24-bit two's-complement audio samples, one for the left channel and one for the right, over a single serial data line. Each frame has two halves, one per channel. A frame clock marks which channel is being sent, and one data bit goes out per bit clock. Two frame formats are supported. In the left-justified format the word starts in the first bit slot of its half. In the I2S format the word starts one slot later, and the frame clock has the opposite polarity.

The port can run as clock master or as clock slave. As master it receives a bit-clock tick from elsewhere and drives both the bit clock and the frame clock, with 64 bit clocks per frame. As slave it oversamples an external bit clock and frame clock, and it restarts its slot count on every frame-clock change, so frames of other lengths still work. New samples arrive with a valid strobe and wait in a staging register. At the start of each left half both words move into the shift holding register. The power-down input forces every driven output low.

Top module: `stereo_serial_tx`

## Requirements
- R1: Each channel word is 24 bits and is sent most significant bit first. The bits are sent unchanged, so the two's-complement value is kept.
- R2: Left-justified format (fmt_i2s=0): the frame clock is 1 during the left half and 0 during the right half. Bit 23 appears in the first bit slot after the frame-clock change.
- R3: I2S format (fmt_i2s=1): the frame clock is 0 during the left half and 1 during the right half. Bit 23 appears in the second bit slot after the frame-clock change, and the first slot is 0.
- R4: In master mode, sdata and fclk_out change only together with a falling edge of bclk_out. They never change while bclk_out is high.
- R5: Master mode (master_sel=1): bclk_out toggles once per bclk_tick. A frame is 64 bit clocks long with 32 slots at each frame-clock level. bclk_oe and fclk_oe are 1.
- R6: Slave mode (master_sel=0): bit and frame timing follow bclk_in and fclk_in. bclk_out, fclk_out and both enables are 0. The slot count restarts on every frame-clock change, so 24 slots per half carry a full left-justified word.
- R7: While pd is 1, sdata is 0. In master mode bclk_out and fclk_out are also 0.
- R8: Every bit slot after the last data bit of a half is 0.
- R9: A word_valid pulse during a frame does not change the words being sent in that frame. The new words are sent from the next frame.
- R10: After reset, sdata, bclk_out and fclk_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | Master mode: one pulse per half bit-clock period |
| pd | input | 1 | Power-down: outputs low, timing state cleared |
| master_sel | input | 1 | 1 = drive clocks, 0 = follow external clocks |
| fmt_i2s | input | 1 | 0 = left-justified, 1 = I2S |
| left_word | input | 24 | Left sample, two's complement |
| right_word | input | 24 | Right sample, two's complement |
| word_valid | input | 1 | Loads both sample words into staging |
| bclk_in | input | 1 | External bit clock (slave) |
| fclk_in | input | 1 | External frame clock (slave) |
| sdata | output | 1 | Serial data |
| bclk_out | output | 1 | Bit clock driven in master mode |
| bclk_oe | output | 1 | Output enable for bclk_out |
| fclk_out | output | 1 | Frame clock driven in master mode |
| fclk_oe | output | 1 | Output enable for fclk_out |

## Verification
In master mode, sdata, fclk_out and bclk_out all change at the same clock edge: the edge at which a tick arrives while bclk_out is high. The bench therefore records one data and frame-clock sample per observed rising bclk_out, half a bit period after that change. In slave mode the result lags a falling bclk_in by three clock edges: two synchroniser stages and the output register. The bench holds each bit-clock level for four clocks and records just before it raises bclk_in. Power-down acts at the next clock edge, so the bench checks the outputs two falling clock edges after raising pd.

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int WORD_W      = 24,
  parameter int FRAME_SLOTS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_tick,
  input  logic              pd,
  input  logic              master_sel,
  input  logic              fmt_i2s,
  input  logic [WORD_W-1:0] left_word,
  input  logic [WORD_W-1:0] right_word,
  input  logic              word_valid,
  input  logic              bclk_in,
  input  logic              fclk_in,
  output logic              sdata,
  output logic              bclk_out,
  output logic              bclk_oe,
  output logic              fclk_out,
  output logic              fclk_oe
);
  localparam int HALF = FRAME_SLOTS / 2;
  localparam int CW   = $clog2(FRAME_SLOTS);
  localparam int IW   = CW + 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_SLOTS - 1);

  logic [WORD_W-1:0] stage_l, stage_r, hold_l, hold_r;
  logic [CW-1:0] mcnt, slot;
  logic [2:0] bsync;
  logic [1:0] lsync;
  logic bck_q, lr_q, sd_q, lr_prev;

  logic [CW-1:0] mcnt_n, slot_n;
  logic [IW-1:0] pos;
  logic [WORD_W-1:0] word, shifted;
  logic left_lvl, lr_now, fall_ev, edge_ev, is_left, cap, bit_ok, bit_val;

  assign left_lvl = ~fmt_i2s;
  assign mcnt_n   = (mcnt == LAST) ? '0 : mcnt + 1'b1;
  assign fall_ev  = master_sel ? (bclk_tick & bck_q) : (bsync[2] & ~bsync[1]);
  assign lr_now   = master_sel ? ((mcnt_n < CW'(HALF)) ? left_lvl : ~left_lvl) : lsync[1];
  assign edge_ev  = master_sel ? (mcnt_n == '0 || mcnt_n == CW'(HALF)) : (lr_now != lr_prev);
  assign slot_n   = edge_ev ? '0 : ((slot == LAST) ? slot : slot + 1'b1);
  assign is_left  = (lr_now == left_lvl);
  assign cap      = edge_ev & is_left;
  assign word     = is_left ? (cap ? stage_l : hold_l) : hold_r;
  assign pos      = {1'b0, slot_n} - IW'(fmt_i2s);
  assign bit_ok   = !(fmt_i2s && slot_n == '0) && (pos < IW'(WORD_W));
  assign shifted  = word << pos;
  assign bit_val  = bit_ok & shifted[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_l <= '0;
      stage_r <= '0;
      hold_l  <= '0;
      hold_r  <= '0;
      mcnt    <= LAST;
      slot    <= LAST;
      bsync   <= '0;
      lsync   <= '0;
      bck_q   <= 1'b0;
      lr_q    <= 1'b0;
      sd_q    <= 1'b0;
      lr_prev <= 1'b0;
    end else begin
      bsync <= {bsync[1:0], bclk_in};
      lsync <= {lsync[0], fclk_in};
      if (word_valid) begin
        stage_l <= left_word;
        stage_r <= right_word;
      end
      if (pd) begin
        bck_q   <= 1'b0;
        lr_q    <= 1'b0;
        sd_q    <= 1'b0;
        mcnt    <= LAST;
        slot    <= LAST;
        lr_prev <= 1'b0;
      end else begin
        if (!master_sel) begin
          bck_q <= 1'b0;
          lr_q  <= 1'b0;
        end else if (bclk_tick) begin
          bck_q <= ~bck_q;
        end
        if (fall_ev) begin
          if (master_sel) begin
            mcnt <= mcnt_n;
            lr_q <= lr_now;
          end
          slot    <= slot_n;
          lr_prev <= lr_now;
          sd_q    <= bit_val;
          if (cap) begin
            hold_l <= stage_l;
            hold_r <= stage_r;
          end
        end
      end
    end
  end

  assign sdata    = sd_q;
  assign bclk_out = bck_q;
  assign fclk_out = lr_q;
  assign bclk_oe  = master_sel;
  assign fclk_oe  = master_sel;
endmodule

module stereo_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pd,
  input logic master_sel,
  input logic sdata,
  input logic bclk_out,
  input logic fclk_out
);
  // R7
  pd_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !sdata);
  // R7
  pd_clocks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && master_sel) |=> (!bclk_out && !fclk_out));
  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && !$stable(sdata)) |-> !bclk_out);
  // R4
  frame_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fclk_out) |-> !bclk_out);
endmodule

bind stereo_serial_tx stereo_serial_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pd(pd), .master_sel(master_sel),
  .sdata(sdata), .bclk_out(bclk_out), .fclk_out(fclk_out)
);

// File: tb/stereo_serial_tx_test.sv
module stereo_serial_tx_test;
  logic clk = 0, rst_n = 0, bclk_tick = 0, pd = 1, master_sel = 0, fmt_i2s = 0;
  logic [23:0] left_word = 0, right_word = 0;
  logic word_valid = 0, bclk_in = 0, fclk_in = 0;
  logic sdata, bclk_out, bclk_oe, fclk_out, fclk_oe;
  logic tick_en = 0, rec_en = 0, rx_d = 0, sd_d = 0, fc_d = 0;
  logic rec_lr [512];
  logic rec_sd [512];
  int rec_n = 0, viol = 0, checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stereo_serial_tx uut (.*);

  always @(negedge clk) bclk_tick <= tick_en ? ~bclk_tick : 1'b0;

  always @(negedge clk) begin
    logic rx;
    rx = master_sel ? bclk_out : bclk_in;
    if (!rec_en) rec_n <= 0;
    else if (rx && !rx_d && rec_n < 512) begin
      rec_lr[rec_n] <= master_sel ? fclk_out : fclk_in;
      rec_sd[rec_n] <= sdata;
      rec_n <= rec_n + 1;
    end
    rx_d <= rx;
    if (master_sel && bclk_out && (sdata != sd_d || fclk_out != fc_d)) viol <= viol + 1;
    sd_d <= sdata;
    fc_d <= fclk_out;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    left_word = l; right_word = r; word_valid = 1;
    @(negedge clk);
    word_valid = 0;
  endtask

  task automatic wait_rec(input int n);
    while (rec_n < n) @(negedge clk);
  endtask

  task automatic decode(input int from, input logic f, output logic [23:0] l,
                        output logic [23:0] r, output int ls, output int rs);
    logic lv;
    lv = ~f; ls = -1; rs = -1; l = 0; r = 0;
    for (int i = from; i < rec_n && ls < 0; i++)
      if (rec_lr[i] == lv && rec_lr[i-1] != lv) ls = i;
    if (ls >= 0)
      for (int i = ls + 1; i < rec_n && rs < 0; i++)
        if (rec_lr[i] != lv && rec_lr[i-1] == lv) rs = i;
    for (int k = 0; k < 24; k++) begin
      if (ls >= 0) l[23-k] = rec_sd[ls + int'(f) + k];
      if (rs >= 0) r[23-k] = rec_sd[rs + int'(f) + k];
    end
  endtask

  task automatic master_start(input logic f, input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    pd = 1; tick_en = 0; rec_en = 0; master_sel = 1; fmt_i2s = f;
    repeat (2) @(negedge clk);
    load(l, r);
    pd = 0; rec_en = 1; tick_en = 1;
  endtask

  task automatic slave_run(input logic f, input int half, input int frames);
    @(negedge clk);
    pd = 1; tick_en = 0; rec_en = 0; master_sel = 0; fmt_i2s = f;
    bclk_in = 1; fclk_in = f;
    repeat (4) @(negedge clk);
    pd = 0; rec_en = 1;
    for (int fr = 0; fr < frames; fr++)
      for (int ch = 0; ch < 2; ch++)
        for (int b = 0; b < half; b++) begin
          bclk_in = 0;
          if (b == 0) fclk_in = (ch == 0) ? ~f : f;
          repeat (4) @(negedge clk);
          bclk_in = 1;
          repeat (4) @(negedge clk);
        end
  endtask

  localparam logic [48:0] VEC [4] = '{
    {1'b0, 24'h800001, 24'h7FFFFE},
    {1'b1, 24'hA5C3F0, 24'h0F1E2D},
    {1'b0, 24'hFFFFFF, 24'h000000},
    {1'b1, 24'h123456, 24'hFEDCBA}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] l, r;
    int ls, rs, cnt;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sdata == 0, "R10 sdata", sdata, 0);
    chk(bclk_out == 0 && fclk_out == 0, "R10 clocks", {bclk_out, fclk_out}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(sdata == 0 && bclk_out == 0, "R10 after release", {sdata, bclk_out}, 0);

    foreach (VEC[v]) begin
      master_start(VEC[v][48], VEC[v][47:24], VEC[v][23:0]);
      wait_rec(200);
      decode(40, VEC[v][48], l, r, ls, rs);
      // R1 R2 R3 words, order and polarity
      chk(l == VEC[v][47:24], VEC[v][48] ? "R3 left word" : "R2 left word", l, VEC[v][47:24]);
      chk(r == VEC[v][23:0], VEC[v][48] ? "R3 right word" : "R1 right word", r, VEC[v][23:0]);
      chk(rs - ls == 32, "R5 half length", rs - ls, 32);
      cnt = 0;
      for (int i = 0; i < 64; i++) if (rec_lr[ls + i] == ~VEC[v][48]) cnt++;
      chk(cnt == 32, "R5 left-level slots", cnt, 32);
      chk(rec_lr[ls + 64] == ~VEC[v][48] && rec_lr[ls + 63] != ~VEC[v][48],
          "R5 frame length", rec_lr[ls + 64], ~VEC[v][48]);
      cnt = 0;
      for (int k = 24 + int'(VEC[v][48]); k < 32; k++) cnt += rec_sd[rs + k] + rec_sd[ls + k];
      chk(cnt == 0, "R8 tail slots", cnt, 0);
      if (VEC[v][48]) chk(rec_sd[ls] == 0, "R3 delay slot", rec_sd[ls], 0);
      chk(bclk_oe && fclk_oe, "R5 enables", {bclk_oe, fclk_oe}, 2'b11);
    end

    // R9 mid-frame update
    master_start(0, 24'hC0FFEE, 24'h13579B);
    wait_rec(75);
    load(24'h2468AC, 24'hDEAD01);
    wait_rec(200);
    decode(40, 0, l, r, ls, rs);
    chk(l == 24'hC0FFEE && r == 24'h13579B, "R9 current frame", {l, r}, {24'hC0FFEE, 24'h13579B});
    decode(100, 0, l, r, ls, rs);
    chk(l == 24'h2468AC && r == 24'hDEAD01, "R9 next frame", {l, r}, {24'h2468AC, 24'hDEAD01});

    // R7 power-down in master
    master_start(0, 24'hFFFFFF, 24'hFFFFFF);
    wait_rec(70);
    chk(sdata == 1, "R1 data bit high", sdata, 1);
    pd = 1;
    repeat (2) @(negedge clk);
    chk(sdata == 0 && bclk_out == 0 && fclk_out == 0, "R7 outputs low",
        {sdata, bclk_out, fclk_out}, 0);
    chk(viol == 0, "R4 change while bclk high", viol, 0);

    // R6 slave, 24 slots per half, left-justified
    load(24'h9ABCDE, 24'h654321);
    slave_run(0, 24, 3);
    decode(10, 0, l, r, ls, rs);
    chk(l == 24'h9ABCDE && r == 24'h654321, "R6 slave 48-slot frame", {l, r}, {24'h9ABCDE, 24'h654321});
    chk(!bclk_oe && !fclk_oe && !bclk_out && !fclk_out, "R6 slave outputs",
        {bclk_oe, fclk_oe, bclk_out, fclk_out}, 0);

    // R6 slave, I2S
    load(24'h7FFFFF, 24'h800000);
    slave_run(1, 32, 3);
    decode(10, 1, l, r, ls, rs);
    chk(l == 24'h7FFFFF && r == 24'h800000, "R6 slave I2S", {l, r}, {24'h7FFFFF, 24'h800000});
    chk(rec_sd[ls] == 0, "R3 slave delay slot", rec_sd[ls], 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule